// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of an SDRAM interface on each rising clock edge and turns each sample into one named command. The pins watched are chip select, the row strobe, the column strobe, write enable, the two bank-select bits, the address bus and the clock-enable pin. The address bit at position 10 and the clock-enable value from the previous cycle take part in the decode. This lets the block tell single-bank precharge from all-bank precharge, plain read or write from the variants with automatic precharge, and ordinary commands from power-down, self-refresh and frozen-clock cycles.

For each of the four banks the block keeps an idle or active flag and the row last opened in that bank. Each command is checked against this state. A command that the current state forbids is still reported, but it also raises a one-cycle error pulse and the bank state stays as it was. All outputs are registered and take effect at the same edge that samples the pins. The block is meant for a protocol monitor or a memory-model front end. Timing parameters and the data bus are outside its scope.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: While chip select (cs_ni) is sampled high and clock enable is high in both this and the previous cycle, the command is deselect and no bank state changes, whatever the other pins hold.
- R2: The pin pattern {ras_ni,cas_ni,we_ni}=011 with cs_ni low is activate. If the bank chosen by ba_i is idle, that bank becomes active, its open row takes addr_i[12:0], and field_o shows the row. bank_o always shows the sampled ba_i.
- R3: An activate to a bank that is already active reports the activate with err_o high for one cycle, and it leaves the bank's flag and open row unchanged.
- R4: The pattern 010 is precharge. With addr_i[10]=0 only the addressed bank goes idle. With addr_i[10]=1 every bank goes idle. Both forms are legal in any state, including when all banks are already idle.
- R5: The pattern 101 is read and 100 is write. field_o shows addr_i[8:0] zero-extended, and auto_pre_o shows addr_i[10]. If the target bank is idle, err_o is raised.
- R6: A legal read or write with addr_i[10]=1 returns the target bank to idle.
- R7: Mode-register set (000) and auto refresh (001) are legal only when all banks are idle. Otherwise err_o is raised and bank state is unchanged.
- R8: When clock enable was high in the previous cycle and is low now, the sample is decoded as follows. If all banks are idle, it is self-refresh entry when cs_ni is low and the pattern is 001, and power-down entry otherwise. If any bank is active and the pattern is not self-refresh, the command is decoded normally. In every cycle where the previous clock enable was low, the command is frozen and no bank state changes.
- R9: A self-refresh entry while any bank is active raises err_o.
- R10: While rst_ni is low, every bank is idle, every open row is 0, cmd_o is 0 and err_o is 0.
- R11: cmd_o is one-hot, with bit index 0 deselect, 1 no-operation (111), 2 activate, 3 precharge one, 4 precharge all, 5 read, 6 read with auto precharge, 7 write, 8 write with auto precharge, 9 mode set, 10 refresh, 11 burst stop (110), 12 self-refresh entry, 13 power-down entry, 14 frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| ba_i | input | 2 | Bank select |
| addr_i | input | 13 | Address bus |
| cmd_o | output | 15 | One-hot decoded command |
| bank_o | output | 2 | Sampled bank select |
| field_o | output | 13 | Row for activate, column for read/write, else 0 |
| auto_pre_o | output | 1 | Auto-precharge request of read/write |
| err_o | output | 1 | Illegal-command pulse |
| bank_active_o | output | 4 | Per-bank active flag |
| open_row_o | output | 52 | Open row per bank, bank i at bits [13*i +: 13] |

## Verification
The assertions check on every cycle that cmd_o is one-hot and that an error or frozen cycle leaves all bank flags and rows unchanged. They also check that a legal activate marks its bank active, that precharge-all empties every bank, that the auto-precharge flag follows the command variant, and that a legal auto-precharge access closes its bank. Only the bench scenarios can show the decode of each pin pattern into the right command index, the exact row and column fields, and the legality decisions that depend on what came before. Examples are a second activate to an open bank, refresh with one bank open, and the clock-enable sequences that give power-down, self-refresh and frozen cycles.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  localparam int NCMD = 15;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_PRE   = 4'd3,
    CMD_PREA  = 4'd4,
    CMD_RD    = 4'd5,
    CMD_RDA   = 4'd6,
    CMD_WR    = 4'd7,
    CMD_WRA   = 4'd8,
    CMD_MRS   = 4'd9,
    CMD_REF   = 4'd10,
    CMD_BST   = 4'd11,
    CMD_SREF  = 4'd12,
    CMD_PDN   = 4'd13,
    CMD_FRZ   = 4'd14
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cke_q_i,
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic ap_i,
  input  logic all_idle_i,
  input  logic tgt_active_i,
  output cmd_e cmd_o,
  output logic legal_o
);
  logic sref_pat;
  assign sref_pat = !cs_ni && !ras_ni && !cas_ni && we_ni;

  always_comb begin
    cmd_o   = CMD_NOP;
    legal_o = 1'b1;
    if (!cke_q_i) begin
      cmd_o = CMD_FRZ;
    end else if (!cke_i && sref_pat) begin
      cmd_o   = CMD_SREF;
      legal_o = all_idle_i;
    end else if (!cke_i && all_idle_i) begin
      cmd_o = CMD_PDN;
    end else if (cs_ni) begin
      cmd_o = CMD_DESEL;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011: begin cmd_o = CMD_ACT; legal_o = !tgt_active_i; end
        3'b010: cmd_o = ap_i ? CMD_PREA : CMD_PRE;
        3'b101: begin cmd_o = ap_i ? CMD_RDA : CMD_RD; legal_o = tgt_active_i; end
        3'b100: begin cmd_o = ap_i ? CMD_WRA : CMD_WR; legal_o = tgt_active_i; end
        3'b000: begin cmd_o = CMD_MRS; legal_o = all_idle_i; end
        3'b001: begin cmd_o = CMD_REF; legal_o = all_idle_i; end
        3'b110: cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_en_i,
  input  logic             close_en_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      row_o    <= '0;
    end else if (open_en_i) begin
      active_o <= 1'b1;
      row_o    <= row_i;
    end else if (close_en_i) begin
      active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       ras_ni,
  input  logic                       cas_ni,
  input  logic                       we_ni,
  input  logic                       cke_i,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ROW_W-1:0]           addr_i,
  output logic [NCMD-1:0]            cmd_o,
  output logic [BA_W-1:0]            bank_o,
  output logic [ROW_W-1:0]           field_o,
  output logic                       auto_pre_o,
  output logic                       err_o,
  output logic [NUM_BANKS-1:0]       bank_active_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o
);
  logic cke_q;
  cmd_e cmd;
  logic legal;
  logic all_idle;
  logic tgt_active;
  logic [NCMD-1:0] cmd_oh;
  logic [ROW_W-1:0] field_d;

  assign all_idle   = ~|bank_active_o;
  assign tgt_active = bank_active_o[ba_i];

  sdram_cmd_decode u_dec (
    .cke_q_i     (cke_q),
    .cke_i       (cke_i),
    .cs_ni       (cs_ni),
    .ras_ni      (ras_ni),
    .cas_ni      (cas_ni),
    .we_ni       (we_ni),
    .ap_i        (addr_i[AP_BIT]),
    .all_idle_i  (all_idle),
    .tgt_active_i(tgt_active),
    .cmd_o       (cmd),
    .legal_o     (legal)
  );

  always_comb begin
    cmd_oh      = '0;
    cmd_oh[cmd] = 1'b1;
    unique case (cmd)
      CMD_ACT: field_d = addr_i;
      CMD_RD, CMD_RDA, CMD_WR, CMD_WRA:
        field_d = {{(ROW_W-COL_W){1'b0}}, addr_i[COL_W-1:0]};
      default: field_d = '0;
    endcase
  end

  logic is_rw_ap;
  assign is_rw_ap = (cmd == CMD_RDA) || (cmd == CMD_WRA);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    logic open_en;
    logic close_en;
    assign hit      = (ba_i == BA_W'(b));
    assign open_en  = legal && hit && (cmd == CMD_ACT);
    assign close_en = legal && ((cmd == CMD_PREA) ||
                                (hit && ((cmd == CMD_PRE) || is_rw_ap)));
    sdram_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .open_en_i (open_en),
      .close_en_i(close_en),
      .row_i     (addr_i),
      .active_o  (bank_active_o[b]),
      .row_o     (open_row_o[b*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q      <= 1'b1;
      cmd_o      <= '0;
      bank_o     <= '0;
      field_d_q_clear();
    end else begin
      cke_q      <= cke_i;
      cmd_o      <= cmd_oh;
      bank_o     <= ba_i;
      field_o    <= field_d;
      auto_pre_o <= (cmd == CMD_RDA) || (cmd == CMD_WRA);
      err_o      <= !legal;
    end
  end

  task automatic field_d_q_clear();
    field_o    <= '0;
    auto_pre_o <= 1'b0;
    err_o      <= 1'b0;
  endtask
endmodule

// File: rtl/sdram_trk_chk.sv
module sdram_trk_chk
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int BA_W      = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NCMD-1:0]            cmd_o,
  input logic [BA_W-1:0]            bank_o,
  input logic                       auto_pre_o,
  input logic                       err_o,
  input logic [NUM_BANKS-1:0]       bank_active_o,
  input logic [NUM_BANKS*ROW_W-1:0] open_row_o
);
  // R11
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o));
  // R3
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (bank_active_o == $past(bank_active_o)) && (open_row_o == $past(open_row_o)));
  // R8
  frz_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CMD_FRZ] |-> (bank_active_o == $past(bank_active_o)) && (open_row_o == $past(open_row_o)));
  // R2
  act_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_ACT] && !err_o) |-> bank_active_o[bank_o]);
  // R4
  prea_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[CMD_PREA] |-> (bank_active_o == '0));
  // R5
  ap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_RD] || cmd_o[CMD_WR] || cmd_o[CMD_RDA] || cmd_o[CMD_WRA]) |->
      (auto_pre_o == (cmd_o[CMD_RDA] || cmd_o[CMD_WRA])));
  // R6
  ap_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o[CMD_RDA] || cmd_o[CMD_WRA]) && !err_o) |-> !bank_active_o[bank_o]);
endmodule

bind sdram_cmd_tracker sdram_trk_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BA_W(BA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_o(cmd_o), .bank_o(bank_o),
  .auto_pre_o(auto_pre_o), .err_o(err_o), .bank_active_o(bank_active_o),
  .open_row_o(open_row_o)
);

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic [14:0] cmd;
  logic [1:0] bank;
  logic [12:0] field;
  logic ap, err;
  logic [3:0] act;
  logic [51:0] rows;
  int total = 0, bad = 0;

  localparam logic [2:0] P_ACT = 3'b011, P_PRE = 3'b010, P_RD = 3'b101, P_WR = 3'b100;
  localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_BST = 3'b110, P_NOP = 3'b111;

  always #5 clk = ~clk;

  sdram_cmd_tracker u_sdram_cmd_tracker (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .cke_i(cke), .ba_i(ba), .addr_i(addr), .cmd_o(cmd),
    .bank_o(bank), .field_o(field), .auto_pre_o(ap), .err_o(err),
    .bank_active_o(act), .open_row_o(rows)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic csn, input logic [2:0] p, input logic ck,
                       input logic [1:0] b, input logic [12:0] a);
    @(negedge clk);
    cs_n = csn; {ras_n, cas_n, we_n} = p; cke = ck; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [14:0] oh(input int i);
    return 15'(1) << i;
  endfunction

  task automatic t_reset();
    #12;
    chk("R10 cmd", cmd, 0); chk("R10 err", err, 0);
    chk("R10 act", act, 0); chk("R10 rows", rows, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_desel();
    issue(1'b1, P_ACT, 1'b1, 2'd2, 13'h0777);
    chk("R1 cmd", cmd, oh(0)); chk("R1 act", act, 0); chk("R1 err", err, 0);
    issue(1'b0, P_NOP, 1'b1, 2'd0, 13'h0);
    chk("R11 nop", cmd, oh(1));
  endtask

  task automatic t_activate();
    issue(1'b0, P_ACT, 1'b1, 2'd1, 13'h1ABC);
    chk("R2 cmd", cmd, oh(2)); chk("R2 bank", bank, 1); chk("R2 field", field, 13'h1ABC);
    chk("R2 act", act, 4'b0010); chk("R2 row1", rows[13 +: 13], 13'h1ABC); chk("R2 err", err, 0);
    issue(1'b0, P_ACT, 1'b1, 2'd3, 13'h0055);
    chk("R2 act3", act, 4'b1010); chk("R2 row3", rows[39 +: 13], 13'h0055);
  endtask

  task automatic t_act_conflict();
    issue(1'b0, P_ACT, 1'b1, 2'd1, 13'h0123);
    chk("R3 cmd", cmd, oh(2)); chk("R3 err", err, 1);
    chk("R3 row1", rows[13 +: 13], 13'h1ABC); chk("R3 act", act, 4'b1010);
    issue(1'b0, P_BST, 1'b1, 2'd0, 13'h0);
    chk("R3 err pulse", err, 0); chk("R11 bst", cmd, oh(11));
  endtask

  task automatic t_rw();
    issue(1'b0, P_RD, 1'b1, 2'd1, 13'h1BFF);
    chk("R5 rd cmd", cmd, oh(5)); chk("R5 rd field", field, 13'h01FF);
    chk("R5 rd ap", ap, 0); chk("R5 rd err", err, 0);
    issue(1'b0, P_WR, 1'b1, 2'd3, 13'h0412);
    chk("R6 wra cmd", cmd, oh(8)); chk("R6 wra field", field, 13'h0012);
    chk("R6 wra ap", ap, 1); chk("R6 close", act, 4'b0010);
    issue(1'b0, P_RD, 1'b1, 2'd2, 13'h0003);
    chk("R5 idle rd cmd", cmd, oh(5)); chk("R5 idle rd err", err, 1);
    issue(1'b0, P_WR, 1'b1, 2'd1, 13'h0005);
    chk("R5 wr cmd", cmd, oh(7)); chk("R5 wr err", err, 0); chk("R5 wr keeps", act, 4'b0010);
  endtask

  task automatic t_busy_modes();
    issue(1'b0, P_MRS, 1'b1, 2'd0, 13'h0030);
    chk("R7 mrs cmd", cmd, oh(9)); chk("R7 mrs err", err, 1);
    issue(1'b0, P_REF, 1'b1, 2'd0, 13'h0);
    chk("R7 ref cmd", cmd, oh(10)); chk("R7 ref err", err, 1); chk("R7 act", act, 4'b0010);
    issue(1'b0, P_REF, 1'b0, 2'd0, 13'h0);
    chk("R9 sref cmd", cmd, oh(12)); chk("R9 sref err", err, 1); chk("R9 act", act, 4'b0010);
    issue(1'b0, P_PRE, 1'b1, 2'd1, 13'h0400);
    chk("R8 frozen", cmd, oh(14)); chk("R8 frozen act", act, 4'b0010);
  endtask

  task automatic t_precharge();
    issue(1'b0, P_ACT, 1'b1, 2'd0, 13'h0009);
    chk("R2 act0", act, 4'b0011);
    issue(1'b0, P_PRE, 1'b1, 2'd1, 13'h0000);
    chk("R4 pre cmd", cmd, oh(3)); chk("R4 pre one", act, 4'b0001);
    issue(1'b0, P_PRE, 1'b1, 2'd3, 13'h0400);
    chk("R4 prea cmd", cmd, oh(4)); chk("R4 prea all", act, 0);
    issue(1'b0, P_PRE, 1'b1, 2'd2, 13'h0400);
    chk("R4 prea idle err", err, 0);
  endtask

  task automatic t_idle_modes();
    issue(1'b0, P_MRS, 1'b1, 2'd0, 13'h0032);
    chk("R7 mrs ok cmd", cmd, oh(9)); chk("R7 mrs ok err", err, 0);
    issue(1'b0, P_REF, 1'b1, 2'd0, 13'h0);
    chk("R7 ref ok err", err, 0);
  endtask

  task automatic t_cke();
    issue(1'b0, P_NOP, 1'b0, 2'd0, 13'h0);
    chk("R8 pdn", cmd, oh(13)); chk("R8 pdn err", err, 0);
    issue(1'b0, P_ACT, 1'b0, 2'd0, 13'h0011);
    chk("R8 frz low", cmd, oh(14)); chk("R8 frz act", act, 0);
    issue(1'b0, P_ACT, 1'b1, 2'd0, 13'h0011);
    chk("R8 frz exit", cmd, oh(14)); chk("R8 exit act", act, 0);
    issue(1'b0, P_ACT, 1'b1, 2'd2, 13'h0005);
    chk("R2 act2", act, 4'b0100);
    issue(1'b0, P_RD, 1'b0, 2'd2, 13'h0007);
    chk("R8 suspend entry cmd", cmd, oh(5)); chk("R8 suspend err", err, 0);
    issue(1'b0, P_PRE, 1'b0, 2'd2, 13'h0000);
    chk("R8 suspended", cmd, oh(14)); chk("R8 suspended act", act, 4'b0100);
    issue(1'b0, P_NOP, 1'b1, 2'd0, 13'h0);
    issue(1'b0, P_NOP, 1'b1, 2'd0, 13'h0);
    chk("R8 resumed", cmd, oh(1));
    issue(1'b0, P_PRE, 1'b1, 2'd0, 13'h0400);
    issue(1'b0, P_REF, 1'b0, 2'd0, 13'h0);
    chk("R8 sref ok", cmd, oh(12)); chk("R8 sref err", err, 0);
    issue(1'b0, P_NOP, 1'b1, 2'd0, 13'h0);
    chk("R8 sref exit", cmd, oh(14));
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_desel();
    t_activate();
    t_act_conflict();
    t_rw();
    t_busy_modes();
    t_precharge();
    t_idle_modes();
    t_cke();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule